// File: doc/BRIEF.md
# Dual-Clock FIFO with Read-Stall Watchdog

This block carries a stream of data words from a producer on one clock to a consumer on another, unrelated clock. Storage is a small register array written on the write clock and read on the read clock. Each side keeps its own position counter. The counter travels to the opposite side as a reflected-binary (Gray) value through a chain of receiving-clock flops. The full and empty indications are computed only from these delayed views, so both are conservative and never unsafe.

The read port works in look-ahead style. While `empty` is low, `rd_data` already shows the oldest stored word, and a read strobe discards that word.

A supervisor in the write domain covers the case where the consumer stops, for example because its clock is gated. It counts write-clock cycles during which the producer is blocked, meaning the buffer is full and a write is waiting, and the delayed read position has not moved. When that count reaches a limit set on an input port, it raises a fault flag. The flag stays set until the producer side pulses a clear.

Top module: `dual_clk_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with no loss and no duplication. While `empty` is 0, `rd_data` shows the oldest stored word. A read strobe sampled with `empty` at 0 removes that word.
- R2: Each position value sent across the clock boundary is the Gray form of the binary count, g = b XOR (b >> 1). It changes in at most one bit from one write-clock (or read-clock) edge to the next.
- R3: Every crossing bit passes through `SYNC_STAGES` (two or more) flops clocked by the receiving side. Logic uses only the last flop of the chain.
- R4: After reset `empty` is 1. After the first write into an empty buffer, `empty` stays 1 at the first read-clock edge that follows. It falls only after the crossing delay. This delay is expected behaviour, not an error.
- R5: After reset `full` is 0. With no reads, `full` is 0 after 2^ADDR_W − 1 writes and becomes 1 on the edge that accepts the 2^ADDR_W-th write.
- R6: A write strobe sampled while `full` is 1 is ignored. It neither stores a word nor moves the write position.
- R7: A read strobe sampled while `empty` is 1 is ignored. It does not move the read position, so the next word written is still read correctly.
- R8: The supervisor counts write-clock cycles with `full` and `wr_en` both at 1 and no change in the delayed read position. Any change in that position returns the count to zero. `fault` becomes 1 once the count reaches `wd_limit`.
- R9: `fault` stays 0 while the reader is running, even slowly, provided its read interval is below the limit. It also stays 0 while the buffer is full but no write is waiting.
- R10: `fault` is 0 after reset. Once set, it stays set even after the reader resumes, until `fault_clr` is sampled at 1. That clear drops `fault` at the next write-clock edge and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No space for another word |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, removes the word on `rd_data` |
| rd_data | output | DATA_W | Oldest stored word (valid while `empty` is 0) |
| empty | output | 1 | No word available |
| wd_limit | input | WD_CNT_W | Stall cycles (write clock) before the fault is raised |
| fault_clr | input | 1 | Write-domain pulse that clears the fault |
| fault | output | 1 | Sticky reader-stall fault |

## Verification
The bench builds the block with 8-bit words and an 8-entry store (ADDR_W = 3), so the full boundary is reached within a few writes and the position wraps several times during one run. It uses three synchronizer stages, which makes the look-ahead delay on `empty` long enough to observe at the first read edge. The watchdog limit is set to 40 write cycles, with a 4 ns write clock and a 7 ns read clock. A reader that consumes one word every four read cycles (about seven write cycles) therefore stays well under the limit. Stopping the read clock and holding a write against a full buffer exceeds the limit within about a hundred cycles.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // smallest number of receiving-clock flops allowed on a crossing
  localparam int unsigned AFIFO_MIN_SYNC = 2;

  // supervisor state: quiet or tripped
  typedef enum logic {
    WD_QUIET   = 1'b0,
    WD_TRIPPED = 1'b1
  } wd_state_e;

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import afifo_pkg::*;

  localparam int unsigned NST = (STAGES < AFIFO_MIN_SYNC) ? AFIFO_MIN_SYNC : STAGES;

  logic [W-1:0] stg [NST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < NST; i++) stg[i] <= stg[i-1];
    end
  end

  // only the last flop feeds logic (R3)
  assign q = stg[NST-1];

endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_fire,
  output logic              full
);
  localparam int unsigned PW = ADDR_W + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // a full buffer puts the writer one lap ahead: top two Gray bits differ
  function automatic logic [PW-1:0] lap_ahead(input logic [PW-1:0] g);
    return g ^ {2'b11, {(PW-2){1'b0}}};
  endfunction

  logic [PW-1:0] wbin, wbin_nxt, wgray_nxt;
  logic          full_nxt;

  assign wr_fire   = wr_en & ~full;
  assign wbin_nxt  = wbin + {{(PW-1){1'b0}}, wr_fire};
  assign wgray_nxt = to_gray(wbin_nxt);
  assign full_nxt  = (wgray_nxt == lap_ahead(rgray_sync));
  assign waddr     = wbin[ADDR_W-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
      full  <= full_nxt;
    end
  end

  AST_WR_GRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);                                   // R2
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wgray));                                      // R6

endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_fire,
  output logic              empty
);
  localparam int unsigned PW = ADDR_W + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] rbin, rbin_nxt, rgray_nxt;
  logic          empty_nxt;

  assign rd_fire   = rd_en & ~empty;
  assign rbin_nxt  = rbin + {{(PW-1){1'b0}}, rd_fire};
  assign rgray_nxt = to_gray(rbin_nxt);
  assign empty_nxt = (rgray_nxt == wgray_sync);
  assign raddr     = rbin[ADDR_W-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rgray_nxt;
      empty <= empty_nxt;
    end
  end

  AST_RD_GRAY_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);                                   // R2
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> $stable(rgray));                                     // R7

endmodule

// File: rtl/afifo_stall_wd.sv
module afifo_stall_wd #(
  parameter int unsigned PW    = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic [PW-1:0]    rgray_sync,
  input  logic             stall,
  input  logic [CNT_W-1:0] limit,
  input  logic             fault_clr,
  output logic             fault
);
  import afifo_pkg::*;

  logic [PW-1:0]    ptr_seen;
  logic [CNT_W-1:0] cnt;
  logic             ptr_moved, cnt_sat, trip;
  wd_state_e        state;

  assign ptr_moved = (ptr_seen != rgray_sync);
  assign cnt_sat   = &cnt;
  assign trip      = stall && !ptr_moved && (cnt >= limit);
  assign fault     = (state == WD_TRIPPED);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      ptr_seen <= '0;
      cnt      <= '0;
      state    <= WD_QUIET;
    end else begin
      ptr_seen <= rgray_sync;
      if (fault_clr || ptr_moved)
        cnt <= '0;
      else if (stall && !cnt_sat)
        cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
      if (fault_clr)
        state <= WD_QUIET;
      else if (trip)
        state <= WD_TRIPPED;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n)
    (fault && !fault_clr) |=> fault);                                         // R10
  AST_FAULT_CLEARS: assert property (@(posedge wclk) disable iff (!wrst_n)
    fault_clr |=> !fault);                                                    // R10
  AST_FAULT_NEEDS_STALL: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(fault) |-> $past(stall));                                           // R8

endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WD_CNT_W    = 16
) (
  input  logic                wclk,
  input  logic                wrst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                full,
  input  logic                rclk,
  input  logic                rrst_n,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                empty,
  input  logic [WD_CNT_W-1:0] wd_limit,
  input  logic                fault_clr,
  output logic                fault
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wgray, rgray, wgray_r, rgray_w;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire, rd_fire, wr_stall;

  afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_sync(rgray_w),
    .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire), .full(full)
  );

  afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_sync(wgray_r),
    .rgray(rgray), .raddr(raddr), .rd_fire(rd_fire), .empty(empty)
  );

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
  );

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
  );

  assign wr_stall = full & wr_en;

  afifo_stall_wd #(.PW(PW), .CNT_W(WD_CNT_W)) u_wd (
    .wclk(wclk), .wrst_n(wrst_n), .rgray_sync(rgray_w), .stall(wr_stall),
    .limit(wd_limit), .fault_clr(fault_clr), .fault(fault)
  );

  always_ff @(posedge wclk) begin
    if (wr_fire) store[waddr] <= wr_data;
  end

  assign rd_data = store[raddr];

  AST_READ_NEEDS_DATA: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_fire |-> !empty);                                                      // R7

endmodule

// File: tb/tb_dual_clk_fifo.sv
`timescale 1ns/1ps
module tb_dual_clk_fifo;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = 12;
  localparam int LIMIT  = 40;

  logic wclk = 0, rclk = 0, rclk_en = 1;
  logic wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, rd_en = 0, fault_clr = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic full, empty, fault;
  logic [CNT_W-1:0] wd_limit = CNT_W'(LIMIT);

  dual_clk_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(3), .WD_CNT_W(CNT_W)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
    .wd_limit(wd_limit), .fault_clr(fault_clr), .fault(fault)
  );

  always #2 wclk = ~wclk;
  always begin #3.5; if (rclk_en) rclk = ~rclk; end

  int n_chk = 0, n_bad = 0, popped = 0, throttle = 1;
  bit mon_en = 0, rd_force = 0, finished = 0;
  logic [DATA_W-1:0] exp_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // writer: hold strobe until accepted; called at a wclk negedge
  task automatic push(input logic [DATA_W-1:0] d);
    bit ok;
    wr_data = d;
    wr_en = 1;
    do begin
      ok = !full;
      @(negedge wclk);
    end while (!ok);
    exp_q.push_back(d);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge wclk);
    repeat (20) @(negedge wclk);
    check(exp_q.size() == 0, "R1 drain", exp_q.size(), 0);
  endtask

  // monitor: compares every delivered word with the queue head
  initial begin
    int tick = 0;
    forever begin
      @(negedge rclk);
      if (rd_force) begin
        rd_en = 1;
      end else if (mon_en && !empty) begin
        tick++;
        if (tick >= throttle) begin
          tick = 0;
          if (exp_q.size() == 0) begin
            check(0, "R1 unexpected word", rd_data, 0);
          end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            check(rd_data == e, "R1 order", rd_data, e);
          end
          popped++;
          rd_en = 1;
        end else rd_en = 0;
      end else rd_en = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge wclk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    repeat (12) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    repeat (4) @(negedge wclk);
    check(empty == 1, "R4 empty after reset", empty, 1);
    check(full == 0, "R5 full after reset", full, 0);
    check(fault == 0, "R10 fault after reset", fault, 0);

    // R4: crossing delay on first write
    mon_en = 1; throttle = 1;
    push(8'hA1); wr_en = 0;
    @(negedge rclk);
    check(empty == 1, "R4 empty held after first write", empty, 1);
    repeat (20) @(negedge rclk);
    check(popped == 1, "R4 word delivered later", popped, 1);

    // R5/R6: fill with reader off, then attempt extra write
    mon_en = 0;
    repeat (10) @(negedge wclk);
    for (int i = 0; i < DEPTH - 1; i++) push(8'h10 + 8'(i));
    wr_en = 0;
    check(full == 0, "R5 not full one short", full, 0);
    push(8'h1F); wr_en = 0;
    check(full == 1, "R5 full at depth", full, 1);
    wr_data = 8'hEE; wr_en = 1;
    repeat (3) @(negedge wclk);
    wr_en = 0;
    check(full == 1, "R6 still full after ignored write", full, 1);
    base = popped;
    mon_en = 1;
    wait_drain();
    check(popped - base == DEPTH, "R6 ignored word not stored", popped - base, DEPTH);
    check(full == 0, "R5 full clears after drain", full, 0);

    // R7: read strobes while empty
    mon_en = 0;
    repeat (5) @(negedge rclk);
    rd_force = 1;
    repeat (10) @(negedge rclk);
    rd_force = 0;
    check(empty == 1, "R7 empty under forced reads", empty, 1);
    @(negedge wclk);
    push(8'h5A); wr_en = 0;
    mon_en = 1;
    wait_drain();

    // R1/R9: slow running reader, writer blocked often, no fault
    throttle = 4;
    for (int i = 0; i < 30; i++) push(8'h40 + 8'(i));
    wr_en = 0;
    wait_drain();
    check(fault == 0, "R9 no fault with slow reader", fault, 0);
    throttle = 1;

    // R9: reader clock stopped, buffer full, no write pending
    mon_en = 0;
    repeat (10) @(negedge rclk);
    rclk_en = 0;
    for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i));
    wr_en = 0;
    repeat (100) @(negedge wclk);
    check(fault == 0, "R9 no fault without pending write", fault, 0);

    // R8: pending write against a frozen reader
    wr_data = 8'hCC; wr_en = 1;
    repeat (20) @(negedge wclk);
    check(fault == 0, "R8 no fault before limit", fault, 0);
    repeat (80) @(negedge wclk);
    check(fault == 1, "R8 fault after limit", fault, 1);
    wr_en = 0;

    // R10: sticky across resume, then cleared
    rclk_en = 1; mon_en = 1;
    wait_drain();
    check(fault == 1, "R10 fault sticky after resume", fault, 1);
    fault_clr = 1;
    @(negedge wclk);
    fault_clr = 0;
    check(fault == 0, "R10 fault cleared", fault, 0);
    repeat (60) @(negedge wclk);
    check(fault == 0, "R10 stays clear", fault, 0);

    finish_run();
  end

endmodule